// File: doc/BRIEF.md
# Circular Reverb Work-Area Address Generator

This block turns signed tap offsets into absolute word addresses inside a circular work area of a 20-bit word-addressed sample memory. Each audio core has its own copy. The work area is bounded by a start register and an end register, both held inside the block. The tap offsets arrive as register values from the surrounding register file, together with a one-cycle strobe that marks any write to the offset range. There are twenty directly programmed taps: eight accumulator sources, four IIR destinations, four IIR sources and four mix destinations. Four further feedback taps are derived as mix-destination offsets minus one of two shared feedback offsets.

The block does not resolve addresses on every access. It resolves every tap ahead of time and holds the results in a registered array. A new pass runs only when the area size changes or an offset write has marked the table dirty. As a result, a register file that writes an offset as two halves triggers the realignment only after both halves have landed. Each pass uses a sequential remainder unit for the modulo. A busy output stays high until every tap is resolved, and the whole array is then replaced in a single cycle.

Top module: `rvb_addr_gen`

## Requirements
- R1: A pass starts only when the area size (end minus start plus one, modulo 2^20) differs from the size seen at the last evaluation, or the dirty flag is set. Offset changes without the strobe, and moving the area while keeping its size, leave `tap_addr` and `busy` unchanged.
- R2: If the size is zero, no pass runs. `busy` stays low, `tap_addr` keeps its old values and the dirty flag is cleared, so a later strobe at size zero also leaves the taps unchanged.
- R3: With p = start + offset, where offset is a signed two's-complement value: if p lies inside [start, end], the tap is p. If p > end, the tap is start + (offset mod size). If p < start, the tap is end + 1 - (|offset| mod size), or start when that remainder is zero. Every result lies inside the area.
- R4: Taps 0..7 are accumulator sources, 8..11 IIR destinations, 12..15 IIR sources and 16..19 mix destinations, each taken from `base_ofs` at the same index. Taps 20 and 21 use mix offsets 16 and 17 minus `fb_ofs_a`. Taps 22 and 23 use mix offsets 18 and 19 minus `fb_ofs_b`. The difference is exact at OFS_W+1 bits.
- R5: After reset, start = 0xEFFF8 + 0x10000×CORE_IDX and end = 0xEFFFF + 0x10000×CORE_IDX. While reset is asserted, `busy` is low and all taps are zero. Because the size register resets to zero, the first pass runs by itself after reset.
- R6: A pulse on `ofs_wr` sets the dirty flag, and this takes priority over clearing it. A pulse while a pass is running causes one more complete pass, which starts right after the current one commits.
- R7: `tap_addr` changes only on the single cycle after a pass completes, with all entries updated together. `busy` is high from the start of a pass until that commit, and the old array remains visible throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Write strobe for the area start register |
| start_wdata | input | ADDR_W | New area start word address |
| end_we | input | 1 | Write strobe for the area end register |
| end_wdata | input | ADDR_W | New area end word address |
| ofs_wr | input | 1 | Strobe: some tap offset register was written |
| base_ofs | input | 20×OFS_W | Signed offsets of the twenty programmed taps, index = tap number |
| fb_ofs_a | input | OFS_W | Shared signed feedback offset for the A set |
| fb_ofs_b | input | OFS_W | Shared signed feedback offset for the B set |
| busy | output | 1 | A resolve pass is in progress |
| tap_addr | output | 24×ADDR_W | Resolved absolute word address for each tap |

## Verification
The hardest situation to reach is an offset strobe that arrives in the middle of a pass. From the ports, it looks like a single pass that finishes with the wrong values unless the block notices the late write. The stimulus waits about a hundred cycles into a pass, changes every offset and pulses the strobe. It then checks three things: the old table is still visible, `busy` rises again right after the first commit, and the final table matches the new offsets. A size-zero area is reached by writing start and end in the same cycle with end one below start. A same-size move of the area is also reached with simultaneous writes, so that no intermediate size ever appears.

// File: rtl/rvb_pkg.sv
package rvb_pkg;

  localparam int ACC_TAPS     = 8;
  localparam int IIR_DST_TAPS = 4;
  localparam int IIR_SRC_TAPS = 4;
  localparam int MIX_TAPS     = 4;
  localparam int FB_TAPS      = MIX_TAPS;

  localparam int BASE_TAPS = ACC_TAPS + IIR_DST_TAPS + IIR_SRC_TAPS + MIX_TAPS;
  localparam int TAPS      = BASE_TAPS + FB_TAPS;
  localparam int MIX_FIRST = ACC_TAPS + IIR_DST_TAPS + IIR_SRC_TAPS;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_DIV    = 2'd2,
    ST_COMMIT = 2'd3
  } rvb_state_e;

endpackage

// File: rtl/rvb_area_regs.sv
module rvb_area_regs #(
  parameter int ADDR_W   = 20,
  parameter int CORE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_wdata,
  input  logic              end_we,
  input  logic [ADDR_W-1:0] end_wdata,
  output logic [ADDR_W-1:0] area_lo,
  output logic [ADDR_W-1:0] area_hi,
  output logic [ADDR_W-1:0] area_size
);

  localparam logic [ADDR_W-1:0] LO_RST = ADDR_W'(32'h000E_FFF8 + 32'h0001_0000 * CORE_IDX);
  localparam logic [ADDR_W-1:0] HI_RST = ADDR_W'(32'h000E_FFFF + 32'h0001_0000 * CORE_IDX);

  // size wraps modulo 2^ADDR_W; a full-memory area therefore reads as zero
  function automatic logic [ADDR_W-1:0] span(input logic [ADDR_W-1:0] lo,
                                             input logic [ADDR_W-1:0] hi);
    return hi - lo + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_lo <= LO_RST;
      area_hi <= HI_RST;
    end else begin
      if (start_we) area_lo <= start_wdata;
      if (end_we)   area_hi <= end_wdata;
    end
  end

  assign area_size = span(area_lo, area_hi);

endmodule

// File: rtl/rvb_tap_offsets.sv
module rvb_tap_offsets
  import rvb_pkg::*;
#(
  parameter int OFS_W = 20,
  parameter int OW    = OFS_W + 1
) (
  input  logic [BASE_TAPS-1:0][OFS_W-1:0] base_ofs,
  input  logic [OFS_W-1:0]                fb_ofs_a,
  input  logic [OFS_W-1:0]                fb_ofs_b,
  output logic [TAPS-1:0][OW-1:0]         tap_ofs
);

  function automatic logic [OW-1:0] widen(input logic [OFS_W-1:0] v);
    return {{(OW-OFS_W){v[OFS_W-1]}}, v};
  endfunction

  // exact signed difference, one bit wider than the operands
  function automatic logic [OW-1:0] fb_diff(input logic [OFS_W-1:0] mix,
                                            input logic [OFS_W-1:0] shared);
    return widen(mix) - widen(shared);
  endfunction

  for (genvar i = 0; i < BASE_TAPS; i++) begin : g_base
    assign tap_ofs[i] = widen(base_ofs[i]);
  end

  for (genvar k = 0; k < FB_TAPS; k++) begin : g_fb
    logic [OFS_W-1:0] shared;
    if (k < FB_TAPS / 2) begin : g_set_a
      assign shared = fb_ofs_a;
    end else begin : g_set_b
      assign shared = fb_ofs_b;
    end
    assign tap_ofs[BASE_TAPS+k] = fb_diff(base_ofs[MIX_FIRST+k], shared);
  end

endmodule

// File: rtl/rvb_mod_seq.sv
module rvb_mod_seq #(
  parameter int MW = 21,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [MW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] rem,
  output logic          done
);

  localparam int CW = $clog2(MW + 1);

  logic [MW-1:0] quo_sh;
  logic [DW:0]   part;
  logic [CW-1:0] steps_left;
  logic          active;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  function automatic logic [DW:0] rem_step(input logic [DW:0]   r,
                                           input logic          nbit,
                                           input logic [DW-1:0] d);
    logic [DW:0] t;
    t = {r[DW-1:0], nbit};
    if (t >= {1'b0, d}) return t - {1'b0, d};
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_sh     <= '0;
      part       <= '0;
      steps_left <= '0;
      active     <= 1'b0;
      done       <= 1'b0;
    end else if (go) begin
      quo_sh     <= dividend;
      part       <= '0;
      steps_left <= CW'(MW);
      active     <= 1'b1;
      done       <= 1'b0;
    end else if (active) begin
      part       <= rem_step(part, quo_sh[MW-1], divisor);
      quo_sh     <= quo_sh << 1;
      steps_left <= steps_left - CW'(1);
      if (steps_left == CW'(1)) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        done   <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign rem = part[DW-1:0];

endmodule

// File: rtl/rvb_addr_gen.sv
module rvb_addr_gen
  import rvb_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int OFS_W    = 20,
  parameter int CORE_IDX = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_we,
  input  logic [ADDR_W-1:0]               start_wdata,
  input  logic                            end_we,
  input  logic [ADDR_W-1:0]               end_wdata,
  input  logic                            ofs_wr,
  input  logic [BASE_TAPS-1:0][OFS_W-1:0] base_ofs,
  input  logic [OFS_W-1:0]                fb_ofs_a,
  input  logic [OFS_W-1:0]                fb_ofs_b,
  output logic                            busy,
  output logic [TAPS-1:0][ADDR_W-1:0]     tap_addr
);

  localparam int OW    = OFS_W + 1;
  localparam int PW    = ((ADDR_W > OW) ? ADDR_W : OW) + 2;
  localparam int IDX_W = $clog2(TAPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  // magnitude of a signed offset; the most negative value maps to 2^(OW-1)
  function automatic logic [OW-1:0] ofs_mag(input logic [OW-1:0] v);
    logic [OW-1:0] neg;
    neg = ~v + OW'(1);
    return v[OW-1] ? neg : v;
  endfunction

  // circular placement of start+offset inside [lo, hi], given |offset| mod size
  function automatic logic [ADDR_W-1:0] wrap_tap(input logic [ADDR_W-1:0] lo,
                                                 input logic [ADDR_W-1:0] hi,
                                                 input logic [OW-1:0]     ofs,
                                                 input logic [ADDR_W-1:0] r);
    logic signed [PW-1:0] lo_s, hi_s, pos;
    lo_s = $signed({{(PW-ADDR_W){1'b0}}, lo});
    hi_s = $signed({{(PW-ADDR_W){1'b0}}, hi});
    pos  = lo_s + $signed({{(PW-OW){ofs[OW-1]}}, ofs});
    if (pos > hi_s)      return lo + r;
    else if (pos < lo_s) return (r == '0) ? lo : (hi + ADDR_W'(1) - r);
    else                 return pos[ADDR_W-1:0];
  endfunction

  // area registers
  logic [ADDR_W-1:0] area_lo, area_hi, area_size;

  rvb_area_regs #(
    .ADDR_W   (ADDR_W),
    .CORE_IDX (CORE_IDX)
  ) u_area (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_we    (start_we),
    .start_wdata (start_wdata),
    .end_we      (end_we),
    .end_wdata   (end_wdata),
    .area_lo     (area_lo),
    .area_hi     (area_hi),
    .area_size   (area_size)
  );

  // per-tap signed offsets, feedback taps derived
  logic [TAPS-1:0][OW-1:0] all_ofs;

  rvb_tap_offsets #(
    .OFS_W (OFS_W),
    .OW    (OW)
  ) u_ofs (
    .base_ofs (base_ofs),
    .fb_ofs_a (fb_ofs_a),
    .fb_ofs_b (fb_ofs_b),
    .tap_ofs  (all_ofs)
  );

  // control state
  rvb_state_e                  state;
  logic [IDX_W-1:0]            idx;
  logic [ADDR_W-1:0]           snap_lo, snap_hi, snap_size;
  logic [ADDR_W-1:0]           last_size;
  logic                        dirty_q;
  logic [OW-1:0]               ofs_q;
  logic [TAPS-1:0][ADDR_W-1:0] shadow;

  // named internal events
  logic              trigger, pass_start, zero_skip, tap_wr, commit;
  logic [ADDR_W-1:0] tap_wr_addr;
  logic              div_go, div_done;
  logic [ADDR_W-1:0] div_rem;

  assign trigger    = (state == ST_IDLE) && (dirty_q || (area_size != last_size));
  assign zero_skip  = trigger && (area_size == '0);
  assign pass_start = trigger && (area_size != '0);
  assign div_go     = (state == ST_LOAD);
  assign tap_wr     = (state == ST_DIV) && div_done;
  assign commit     = (state == ST_COMMIT);
  assign busy       = (state != ST_IDLE);

  rvb_mod_seq #(
    .MW (OW),
    .DW (ADDR_W)
  ) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (ofs_mag(all_ofs[idx])),
    .divisor  (snap_size),
    .rem      (div_rem),
    .done     (div_done)
  );

  assign tap_wr_addr = wrap_tap(snap_lo, snap_hi, ofs_q, div_rem);

  // dirty flag: a strobe wins over the clear on evaluation
  always_ff @(posedge clk) begin
    if (!rst_n)       dirty_q <= 1'b0;
    else if (ofs_wr)  dirty_q <= 1'b1;
    else if (trigger) dirty_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      snap_lo   <= '0;
      snap_hi   <= '0;
      snap_size <= '0;
      last_size <= '0;
      ofs_q     <= '0;
      shadow    <= '0;
      tap_addr  <= '0;
    end else begin
      if (trigger) last_size <= area_size;
      unique case (state)
        ST_IDLE: begin
          if (pass_start) begin
            snap_lo   <= area_lo;
            snap_hi   <= area_hi;
            snap_size <= area_size;
            idx       <= '0;
            state     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ofs_q <= all_ofs[idx];
          state <= ST_DIV;
        end
        ST_DIV: begin
          if (div_done) begin
            shadow[idx] <= tap_wr_addr;
            if (idx == LAST_IDX) begin
              state <= ST_COMMIT;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_LOAD;
            end
          end
        end
        ST_COMMIT: begin
          tap_addr <= shadow;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rvb_addr_gen_chk.sv
module rvb_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int TAPS   = 24
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic                        ofs_wr,
  input logic                        dirty_q,
  input logic                        zero_skip,
  input logic                        tap_wr,
  input logic                        commit,
  input logic [ADDR_W-1:0]           tap_wr_addr,
  input logic [ADDR_W-1:0]           snap_lo,
  input logic [ADDR_W-1:0]           snap_hi,
  input logic [TAPS-1:0][ADDR_W-1:0] tap_addr
);

  // R7
  hold_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(tap_addr));

  // R7
  commit_ends_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  // R3
  inside_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_wr && (snap_lo <= snap_hi)) |-> ((tap_wr_addr >= snap_lo) && (tap_wr_addr <= snap_hi)));

  // R2
  zero_size_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_skip |=> !busy);

  // R6
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wr |=> dirty_q);

endmodule

bind rvb_addr_gen rvb_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .TAPS   (rvb_pkg::TAPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .ofs_wr      (ofs_wr),
  .dirty_q     (dirty_q),
  .zero_skip   (zero_skip),
  .tap_wr      (tap_wr),
  .commit      (commit),
  .tap_wr_addr (tap_wr_addr),
  .snap_lo     (snap_lo),
  .snap_hi     (snap_hi),
  .tap_addr    (tap_addr)
);

// File: tb/sim_rvb_addr_gen.sv
module sim_rvb_addr_gen;
  import rvb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int OWB = 20;

  typedef struct packed {
    int lo; int hi; int o0; int step; int fa; int fb;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h01000, 32'h01FFF, 0,       16,     32,       48},
    '{32'h02000, 32'h020FF, 128,     64,     -100,     300},
    '{32'h30000, 32'h3000F, -5,      -7,     9,        -9},
    '{32'h00500, 32'h00563, -200,    50,     -100,     200},
    '{32'hE0000, 32'hEFFFF, 524287,  -40000, -524288,  524287},
    '{32'h00777, 32'h00777, 3,       -1,     1,        -1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_we = 1'b0, end_we = 1'b0, ofs_wr = 1'b0;
  logic [AW-1:0] start_wdata = '0, end_wdata = '0;
  logic [BASE_TAPS-1:0][OWB-1:0] base_ofs = '0;
  logic [OWB-1:0] fb_ofs_a = '0, fb_ofs_b = '0;
  logic busy, busy1;
  logic [TAPS-1:0][AW-1:0] tap_addr, tap_addr1;
  logic [BASE_TAPS-1:0][OWB-1:0] zero_ofs = '0;
  logic [OWB-1:0] zero_fb = '0;
  logic [AW-1:0] zero_a = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int cur_lo, cur_hi, cur_o0, cur_step, cur_fa, cur_fb;
  logic [TAPS-1:0][AW-1:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvb_addr_gen #(.ADDR_W(AW), .OFS_W(OWB), .CORE_IDX(0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_wdata(start_wdata),
    .end_we(end_we), .end_wdata(end_wdata), .ofs_wr(ofs_wr), .base_ofs(base_ofs),
    .fb_ofs_a(fb_ofs_a), .fb_ofs_b(fb_ofs_b), .busy(busy), .tap_addr(tap_addr));

  rvb_addr_gen #(.ADDR_W(AW), .OFS_W(OWB), .CORE_IDX(1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_we(1'b0), .start_wdata(zero_a),
    .end_we(1'b0), .end_wdata(zero_a), .ofs_wr(1'b0), .base_ofs(zero_ofs),
    .fb_ofs_a(zero_fb), .fb_ofs_b(zero_fb), .busy(busy1), .tap_addr(tap_addr1));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // signed offset seen by tap i under the current programming
  function automatic longint tap_offset(input int i);
    if (i < BASE_TAPS) return longint'(cur_o0) + longint'(i) * cur_step;
    return longint'(cur_o0) + longint'(MIX_FIRST + i - BASE_TAPS) * cur_step
           - ((i - BASE_TAPS < FB_TAPS/2) ? cur_fa : cur_fb);
  endfunction

  // circular placement written as start + ((offset mod size) normalised)
  function automatic longint model(input longint lo, input longint hi, input longint o);
    longint size, m;
    size = hi - lo + 1;
    m = o % size;
    if (m < 0) m = m + size;
    return lo + m;
  endfunction

  task automatic program_ofs(input int o0, input int step, input int fa, input int fb);
    cur_o0 = o0; cur_step = step; cur_fa = fa; cur_fb = fb;
    for (int i = 0; i < BASE_TAPS; i++) base_ofs[i] = OWB'(o0 + i * step);
    fb_ofs_a = OWB'(fa);
    fb_ofs_b = OWB'(fb);
  endtask

  task automatic pulse_wr(input bit wr_area, input bit wr_ofs);
    start_we = wr_area; end_we = wr_area; ofs_wr = wr_ofs;
    @(negedge clk);
    start_we = 1'b0; end_we = 1'b0; ofs_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int guard;
    guard = 0;
    repeat (3) @(negedge clk);
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check({req, " pass finishes"}, guard < 5000, 1);
  endtask

  task automatic check_table();
    for (int i = 0; i < TAPS; i++)
      check((i < BASE_TAPS) ? "R3 base tap" : "R4 feedback tap",
            tap_addr[i], model(cur_lo, cur_hi, tap_offset(i)));
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen;
    seen = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    program_ofs(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 busy in reset", busy, 0);
    check("R5 taps zero in reset", tap_addr, 0);
    rst_n = 1'b1;
    wait_idle("R5");
    cur_lo = 32'hEFFF8; cur_hi = 32'hEFFFF;
    check("R5 core0 default start", tap_addr[0], 32'hEFFF8);
    check("R5 core0 default feedback", tap_addr[23], 32'hEFFF8);
    repeat (2000) @(negedge clk);
    check("R5 core1 default start", tap_addr1[5], 32'hFFFF8);

    // R5 default area size 8: offsets -4..15 wrap inside 0xEFFF8..0xEFFFF
    program_ofs(-4, 1, 2, -3);
    pulse_wr(1'b0, 1'b1);
    wait_idle("R5");
    check_table();

    // R3 R4 vector table
    for (int v = 0; v < NVEC; v++) begin
      cur_lo = VECS[v].lo; cur_hi = VECS[v].hi;
      start_wdata = AW'(VECS[v].lo);
      end_wdata = AW'(VECS[v].hi);
      program_ofs(VECS[v].o0, VECS[v].step, VECS[v].fa, VECS[v].fb);
      pulse_wr(1'b1, 1'b1);
      wait_idle("R3");
      check_table();
    end

    // R7 old table visible mid-pass, R6 late strobe forces a second pass
    saved = tap_addr;
    cur_lo = 32'h04000; cur_hi = 32'h0403F;
    start_wdata = 20'h04000; end_wdata = 20'h0403F;
    program_ofs(70, -9, 5, 11);
    pulse_wr(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    check("R7 busy mid-pass", busy, 1);
    check("R7 table held mid-pass", tap_addr, saved);
    program_ofs(-130, 13, -17, 40);
    pulse_wr(1'b0, 1'b1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R6 second pass started", busy, 1);
    wait_idle("R6");
    check_table();

    // R1 offsets change without a strobe
    saved = tap_addr;
    program_ofs(1000, 3, 0, 0);
    quiet_window("R1 no pass without strobe", 60);
    check("R1 table kept without strobe", tap_addr, saved);

    // R1 same-size move of the area
    start_wdata = 20'h05000; end_wdata = 20'h0503F;
    pulse_wr(1'b1, 1'b0);
    quiet_window("R1 no pass on same-size move", 60);
    check("R1 table kept on same-size move", tap_addr, saved);

    // R2 zero size: end one below start
    start_wdata = 20'h00100; end_wdata = 20'h000FF;
    pulse_wr(1'b1, 1'b0);
    quiet_window("R2 no pass at size zero", 40);
    check("R2 table kept at size zero", tap_addr, saved);
    program_ofs(7, 7, 7, 7);
    pulse_wr(1'b0, 1'b1);
    quiet_window("R2 strobe at size zero ignored", 40);
    check("R2 table kept after strobe", tap_addr, saved);

    // R2 R1 leaving size zero resolves with current offsets
    cur_lo = 32'h00100; cur_hi = 32'h001FF;
    start_wdata = 20'h00100; end_wdata = 20'h001FF;
    pulse_wr(1'b1, 1'b0);
    wait_idle("R1");
    check_table();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule